// File: doc/BRIEF.md
# Timed Open-Drain Reset Pin Controller

This block runs a single pin that can work in two directions. As an output, software starts a fixed-length active-low pulse by setting a trigger bit in a configuration register. The block only pulls the pin low and never drives it high. When the pulse ends, the block clears the trigger bit by itself. Software may only use the output function after it sets an enable bit in a separate mask register.

When the block is not pulling the pin low, the pin works as an input. The pin is sampled through a synchroniser. An external low level then raises a register-reset strobe. That strobe returns the configuration and control registers to their power-on values, and it also clears the DAC data register in the register file. Stored measurement values are not affected. The block's own pulse is masked so that it never comes back as a reset request.

The pulse length is set as a number of milliseconds and is turned into a clock-cycle count from the system clock frequency, always rounding up.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `rst_n` is low, `pin_oe` and `regfile_rst` are 0, `cfg_q` equals CFG_DEFAULT (8'h01) and `mask2_q` equals MASK_DEFAULT (8'h00).
- R2: A write with `wr_addr` equal to CFG_ADDR (8'h40) loads `cfg_q`, and a write to MASK_ADDR (8'h44) loads `mask2_q`, both visible after the write edge. A write to any other address changes neither register.
- R3: `pin_oe` (1 = pull the pin low; the block has no way to drive it high) rises only when `cfg_q` bit 4 and `mask2_q` bit 7 were both 1 in the previous cycle. It rises one cycle after bit 4 first reads 1.
- R4: Once started, `pin_oe` stays 1 for exactly ceil(CLK_HZ * PULSE_MS / 1000) consecutive cycles, so the low time is never shorter than PULSE_MS.
- R5: `cfg_q` bit 4 reads 1 for the whole pulse. It falls to 0 on the same edge that `pin_oe` falls, with no write, and the other configuration bits are kept.
- R6: During a pulse, writes to the configuration register update every bit except bit 4, and the pulse length does not change.
- R7: If `mask2_q` bit 7 is 0, setting `cfg_q` bit 4 leaves `pin_oe` at 0, and bit 4 reads 0 again one cycle later.
- R8: After an external low on `pin_in`, passed through SYNC_STAGES flops, `regfile_rst` is 1 from the third edge after the pin falls, for as many cycles as the pin stayed low. On the next edge `cfg_q` and `mask2_q` return to their defaults.
- R9: `regfile_rst` stays 0 while `pin_oe` is 1 and for BLANK_CYCLES cycles after it falls, even though the pin then reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| cfg_q | output | DATA_W | Configuration register contents (bit 4 = pulse trigger) |
| mask2_q | output | DATA_W | Mask register contents (bit 7 = output enable) |
| pin_in | input | 1 | Level sampled from the pin |
| pin_oe | output | 1 | Open-drain pull-down enable for the pin |
| regfile_rst | output | 1 | Strobe that resets the control registers and the DAC data register |

## Verification
The bench uses a pulse count that needs rounding up (30.5 cycles becomes 31). A design that truncated would show a pulse one cycle short. It models the pin as a wired-AND of the pull-down and an external driver, so the block's own pulse loops back through the synchroniser. Without the blanking window, `regfile_rst` would fire during or just after the pulse and wipe the enable bit. A write during a pulse that clears bit 4 is checked to neither shorten the pulse nor drop the bit early. The test with the enable bit off catches a trigger bit that sticks or still pulls the pin low. The external-reset test measures the exact start cycle and width of `regfile_rst`, which exposes a missing or extra synchroniser stage.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

   typedef enum logic [0:0] {
      DRV_IDLE = 1'b0,
      DRV_LOW  = 1'b1
   } drv_state_e;

   // Cycles covering ms milliseconds at clk_hz, rounded up.
   function automatic longint unsigned cycles_for_ms(input longint unsigned clk_hz,
                                                     input longint unsigned ms);
      return (clk_hz * ms + 64'd999) / 64'd1000;
   endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b1;
            else        sh[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b1;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign q = sh[STAGES-1];

endmodule

// File: rtl/rstpin_guard.sv
module rstpin_guard #(
   parameter int SYNC_STAGES  = 2,
   parameter int BLANK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic drive,
   input  logic arm,
   output logic ext_rst
);

   localparam int BW = $clog2(BLANK_CYCLES + 1);

   logic          pin_s;
   logic [BW-1:0] blank_cnt;
   logic          blank;

   rstpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   assign blank = drive || arm || (blank_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_cnt <= '0;
      end else if (drive || arm) begin
         blank_cnt <= BW'(BLANK_CYCLES);
      end else if (blank_cnt != '0) begin
         blank_cnt <= blank_cnt - BW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_rst <= 1'b0;
      else        ext_rst <= !pin_s && !blank;
   end

endmodule

// File: rtl/rstpin_timer.sv
module rstpin_timer
   import rstpin_pkg::*;
#(
   parameter int               CNT_W    = 8,
   parameter logic [CNT_W-1:0] LOAD_VAL = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   drv_state_e       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= DRV_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            DRV_IDLE: begin
               if (start) begin
                  state <= DRV_LOW;
                  cnt   <= LOAD_VAL;
               end
            end
            DRV_LOW: begin
               if (cnt == '0) state <= DRV_IDLE;
               else           cnt   <= cnt - CNT_W'(1);
            end
            default: state <= DRV_IDLE;
         endcase
      end
   end

   assign busy = (state == DRV_LOW);
   assign done = busy && (cnt == '0);

endmodule

// File: rtl/rstpin_regs.sv
module rstpin_regs #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = '0,
   parameter logic [ADDR_W-1:0] MASK_ADDR = '1,
   parameter logic [DATA_W-1:0] CFG_DEF   = '0,
   parameter logic [DATA_W-1:0] MASK_DEF  = '0,
   parameter int                TRIG_BIT  = 4,
   parameter int                EN_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic              done,
   input  logic              soft_rst,
   output logic [DATA_W-1:0] cfg_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              start
);

   logic              cfg_hit, mask_hit;
   logic [DATA_W-1:0] cfg_d, mask_d;

   assign cfg_hit  = wr_en && (wr_addr == CFG_ADDR);
   assign mask_hit = wr_en && (wr_addr == MASK_ADDR);
   assign start    = cfg_q[TRIG_BIT] && mask_q[EN_BIT] && !busy && !soft_rst;

   always_comb begin
      cfg_d = cfg_q;
      if (cfg_hit) cfg_d = wr_data;
      if (busy) begin
         cfg_d[TRIG_BIT] = !done;
      end else if (start) begin
         cfg_d[TRIG_BIT] = 1'b1;
      end else if (!cfg_hit && cfg_q[TRIG_BIT]) begin
         cfg_d[TRIG_BIT] = 1'b0;
      end
   end

   assign mask_d = mask_hit ? wr_data : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_DEF;
         mask_q <= MASK_DEF;
      end else if (soft_rst) begin
         cfg_q  <= CFG_DEF;
         mask_q <= MASK_DEF;
      end else begin
         cfg_q  <= cfg_d;
         mask_q <= mask_d;
      end
   end

endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
   import rstpin_pkg::*;
#(
   parameter int                ADDR_W       = 8,
   parameter int                DATA_W       = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR     = 8'h40,
   parameter logic [ADDR_W-1:0] MASK_ADDR    = 8'h44,
   parameter logic [DATA_W-1:0] CFG_DEFAULT  = 8'h01,
   parameter logic [DATA_W-1:0] MASK_DEFAULT = 8'h00,
   parameter int                TRIG_BIT     = 4,
   parameter int                EN_BIT       = 7,
   parameter longint unsigned   CLK_HZ       = 64'd50_000_000,
   parameter longint unsigned   PULSE_MS     = 64'd20,
   parameter int                SYNC_STAGES  = 2,
   parameter int                BLANK_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cfg_q,
   output logic [DATA_W-1:0] mask2_q,
   input  logic              pin_in,
   output logic              pin_oe,
   output logic              regfile_rst
);

   localparam longint unsigned  PULSE_CYCLES = cycles_for_ms(CLK_HZ, PULSE_MS);
   localparam int               CNT_W        = $clog2(PULSE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL     = CNT_W'(PULSE_CYCLES - 1);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("rstpin_ctrl: SYNC_STAGES must be at least 2");
   end
   if (BLANK_CYCLES < SYNC_STAGES) begin : g_chk_blank
      $error("rstpin_ctrl: BLANK_CYCLES must cover the synchroniser depth");
   end
   if (TRIG_BIT >= DATA_W || EN_BIT >= DATA_W) begin : g_chk_bits
      $error("rstpin_ctrl: control bit positions exceed DATA_W");
   end
   if (CFG_ADDR == MASK_ADDR) begin : g_chk_addr
      $error("rstpin_ctrl: register addresses collide");
   end
   if (CFG_DEFAULT[TRIG_BIT]) begin : g_chk_def
      $error("rstpin_ctrl: trigger bit must default to 0");
   end
   if (PULSE_CYCLES < 1) begin : g_chk_len
      $error("rstpin_ctrl: pulse length rounds to zero cycles");
   end

   logic start, busy, done;

   rstpin_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CFG_ADDR  (CFG_ADDR),
      .MASK_ADDR (MASK_ADDR),
      .CFG_DEF   (CFG_DEFAULT),
      .MASK_DEF  (MASK_DEFAULT),
      .TRIG_BIT  (TRIG_BIT),
      .EN_BIT    (EN_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .busy     (busy),
      .done     (done),
      .soft_rst (regfile_rst),
      .cfg_q    (cfg_q),
      .mask_q   (mask2_q),
      .start    (start)
   );

   rstpin_timer #(
      .CNT_W    (CNT_W),
      .LOAD_VAL (LOAD_VAL)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done)
   );

   rstpin_guard #(
      .SYNC_STAGES  (SYNC_STAGES),
      .BLANK_CYCLES (BLANK_CYCLES)
   ) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .drive   (busy),
      .arm     (start),
      .ext_rst (regfile_rst)
   );

   assign pin_oe = busy;

endmodule

// File: rtl/rstpin_chk.sv
module rstpin_chk #(
   parameter int unsigned       PULSE_LEN = 1,
   parameter int                DATA_W    = 8,
   parameter int                TRIG_BIT  = 4,
   parameter int                EN_BIT    = 7,
   parameter logic [DATA_W-1:0] CFG_DEF   = '0,
   parameter logic [DATA_W-1:0] MASK_DEF  = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              pin_oe,
   input logic [DATA_W-1:0] cfg_q,
   input logic [DATA_W-1:0] mask2_q,
   input logic              regfile_rst
);

   int unsigned run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run <= 0;
      else if (pin_oe) run <= run + 1;
      else             run <= 0;
   end

   AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_oe) |-> $past(cfg_q[TRIG_BIT] && mask2_q[EN_BIT])); // R3

   AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_oe) |-> (run == PULSE_LEN)); // R4

   AST_TRIG_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> cfg_q[TRIG_BIT]); // R5

   AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_oe) |-> !cfg_q[TRIG_BIT]); // R5

   AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[TRIG_BIT] && !pin_oe && !mask2_q[EN_BIT] && !wr_en) |=> !cfg_q[TRIG_BIT]); // R7

   AST_EXT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      regfile_rst |=> (cfg_q == CFG_DEF && mask2_q == MASK_DEF)); // R8

   AST_NO_SELF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> !regfile_rst); // R9

endmodule

bind rstpin_ctrl rstpin_chk #(
   .PULSE_LEN (32'(PULSE_CYCLES)),
   .DATA_W    (DATA_W),
   .TRIG_BIT  (TRIG_BIT),
   .EN_BIT    (EN_BIT),
   .CFG_DEF   (CFG_DEFAULT),
   .MASK_DEF  (MASK_DEFAULT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .pin_oe      (pin_oe),
   .cfg_q       (cfg_q),
   .mask2_q     (mask2_q),
   .regfile_rst (regfile_rst)
);

// File: tb/sim_rstpin_ctrl.sv
`timescale 1ns/1ps
module sim_rstpin_ctrl;

   localparam int EXP_LEN = 31;   // ceil(1525 * 20 / 1000)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] cfg_q, mask2_q;
   logic       pin_in, pin_oe, regfile_rst;
   logic       ext_low = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   int run_len = 0;
   int last_len = 0;

   always #10 clk = ~clk;

   assign pin_in = ~(pin_oe | ext_low);

   rstpin_ctrl #(
      .CLK_HZ       (64'd1525),
      .PULSE_MS     (64'd20),
      .BLANK_CYCLES (4)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .cfg_q       (cfg_q),
      .mask2_q     (mask2_q),
      .pin_in      (pin_in),
      .pin_oe      (pin_oe),
      .regfile_rst (regfile_rst)
   );

   always @(negedge clk) begin
      if (pin_oe === 1'b1) begin
         run_len = run_len + 1;
      end else begin
         if (run_len != 0) last_len = run_len;
         run_len = 0;
      end
   end

   // {addr, data, expected cfg, expected mask}
   localparam logic [31:0] VEC [0:7] = '{
      {8'h44, 8'h5A, 8'h01, 8'h5A},
      {8'h40, 8'h2C, 8'h2C, 8'h5A},
      {8'h48, 8'hFF, 8'h2C, 8'h5A},
      {8'h40, 8'hEF, 8'hEF, 8'h5A},
      {8'h44, 8'h00, 8'hEF, 8'h00},
      {8'h00, 8'h77, 8'hEF, 8'h00},
      {8'h40, 8'h00, 8'h00, 8'h00},
      {8'h44, 8'h7F, 8'h00, 8'h7F}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int len, bad_bit, bad_rst, first, hits;

      // R1: state under reset
      repeat (3) @(negedge clk);
      chk(pin_oe == 1'b0, "R1 pin_oe", 32'(pin_oe), 0);
      chk(regfile_rst == 1'b0, "R1 regfile_rst", 32'(regfile_rst), 0);
      chk(cfg_q == 8'h01, "R1 cfg", 32'(cfg_q), 32'h01);
      chk(mask2_q == 8'h00, "R1 mask", 32'(mask2_q), 32'h00);
      rst_n = 1'b1;

      // R2: register write table
      for (int k = 0; k < 8; k++) begin
         wr(VEC[k][31:24], VEC[k][23:16]);
         chk(cfg_q == VEC[k][15:8], "R2 cfg readback", 32'(cfg_q), 32'(VEC[k][15:8]));
         chk(mask2_q == VEC[k][7:0], "R2 mask readback", 32'(mask2_q), 32'(VEC[k][7:0]));
      end

      // R7: trigger with output function disabled (mask = 7F)
      wr(8'h40, 8'h13);
      chk(cfg_q == 8'h13, "R7 bit set seen", 32'(cfg_q), 32'h13);
      @(negedge clk);
      chk(cfg_q == 8'h03, "R7 bit cleared next cycle", 32'(cfg_q), 32'h03);
      hits = 0;
      for (int i = 0; i < 6; i++) begin
         if (pin_oe) hits++;
         @(negedge clk);
      end
      chk(hits == 0, "R7 pin untouched", 32'(hits), 0);

      // R3 R4 R5 R9: enabled pulse
      wr(8'h44, 8'h80);
      wr(8'h40, 8'h35);
      chk(cfg_q == 8'h35 && pin_oe == 1'b0, "R3 no drive on write cycle", 32'(pin_oe), 0);
      @(negedge clk);
      chk(pin_oe == 1'b1, "R3 drive one cycle later", 32'(pin_oe), 1);
      len = 0; bad_bit = 0; bad_rst = 0;
      for (int i = 0; i < 100; i++) begin
         if (!pin_oe) break;
         len++;
         if (!cfg_q[4]) bad_bit++;
         if (regfile_rst) bad_rst++;
         @(negedge clk);
      end
      chk(len == EXP_LEN, "R4 pulse length", 32'(len), 32'(EXP_LEN));
      chk(bad_bit == 0, "R5 trigger held during pulse", 32'(bad_bit), 0);
      chk(cfg_q == 8'h25, "R5 self-clear keeps other bits", 32'(cfg_q), 32'h25);
      chk(bad_rst == 0, "R9 no reset during own pulse", 32'(bad_rst), 0);
      hits = 0;
      for (int i = 0; i < 8; i++) begin
         if (regfile_rst) hits++;
         @(negedge clk);
      end
      chk(hits == 0, "R9 no reset after own pulse", 32'(hits), 0);
      chk(mask2_q == 8'h80, "R9 enable survives", 32'(mask2_q), 32'h80);

      // R6: write clearing bit 4 mid-pulse
      wr(8'h40, 8'h10);
      @(negedge clk);
      repeat (4) @(negedge clk);
      wr(8'h40, 8'h42);
      chk(cfg_q == 8'h52, "R6 bit 4 kept during pulse", 32'(cfg_q), 32'h52);
      chk(pin_oe == 1'b1, "R6 pulse still active", 32'(pin_oe), 1);
      repeat (40) @(negedge clk);
      chk(last_len == EXP_LEN, "R6 pulse length unchanged", 32'(last_len), 32'(EXP_LEN));
      chk(cfg_q == 8'h42 && pin_oe == 1'b0, "R6 end state", 32'(cfg_q), 32'h42);

      // R8: external low on the pin for three cycles
      wr(8'h44, 8'hB3);
      wr(8'h40, 8'h2B);
      repeat (8) @(negedge clk);
      ext_low = 1'b1;
      first = -1; hits = 0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (regfile_rst) begin
            hits++;
            if (first < 0) first = i;
         end
         if (i == 3) ext_low = 1'b0;
      end
      chk(first == 3, "R8 strobe start cycle", 32'(first), 3);
      chk(hits == 3, "R8 strobe width", 32'(hits), 3);
      chk(cfg_q == 8'h01, "R8 cfg default", 32'(cfg_q), 32'h01);
      chk(mask2_q == 8'h00, "R8 mask default", 32'(mask2_q), 32'h00);
      chk(pin_oe == 1'b0, "R8 no drive", 32'(pin_oe), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule